// File: doc/BRIEF.md
# Banked BCD Real-Time Calendar Core

This block keeps time of day and calendar date in packed BCD nibbles. It is read and written through a 4-bit address, a write strobe, 4-bit write data and a registered 4-bit read port. The core clock is also the fast reference clock. A prescaler divides it by `SEC_CYCLES` and produces one update per second. On each update the seconds advance and the carries ripple through minutes, hours, day of week, date, month and a four-digit year.

Address 15 is a control nibble that is visible whatever bank is selected. It holds:
- a 2-bit bank selector,
- a stop bit that freezes counting,
- a dual-purpose bit. On a read it reports that an update is near. On a write of 1 it requests rounding of the seconds to the nearest minute.

Software sets the stop bit, loads the time and clears the stop bit. It polls the busy bit before it reads several fields, so that it never reads a torn value. `GUARD_CYCLES` sets how many reference cycles of guard lie on each side of an update.

Top module: `rtc_nibble_core`

## Requirements
- R1: Nibble map, bank 0:

  | Address | Field |
  |---|---|
  | 0 | seconds units |
  | 1 | seconds tens (bits 2:0) |
  | 2 | minutes units |
  | 3 | minutes tens (bits 2:0) |
  | 4 | hours units |
  | 5 | hours tens (bits 1:0) |
  | 6 | weekday 0..6 (bits 2:0) |
  | 7 | date units |
  | 8 | date tens (bits 1:0) |
  | 9 | month units |
  | 10 | month tens (bit 0) |
  | 11 | year units |
  | 12 | year tens |
  | 13 | year hundreds |
  | 14 | year thousands (bits 1:0) |

  Bits outside these fields read 0, apart from the flag bits named in R11. `rd_data` shows the nibble addressed on the previous clock edge.
- R2: After reset the core holds:
  - time 00:00:00, weekday 0, date 01, month 01, year 0000;
  - address 1 bit 3 (oscillator-stop flag) set to 1;
  - address 14 bits 3:2 cleared;
  - control nibble 0 (bank 0, running).
- R3: The control nibble at address 15 reads {bank[1:0], stop, busy/adjust} in bits 3..0 in every bank. When the bank is not 0, addresses 0..14 read 0 and writes to them are ignored.
- R4: While running, the time advances one second every `SEC_CYCLES` clock cycles. The prescaler is cleared while stop is 1, so the first update lands exactly `SEC_CYCLES` edges after the edge that clears stop.
- R5: While stop is 1, no field changes except by a write or a rounding command.
- R6: Seconds and minutes wrap from 59 to 00 and each carries on. Hours wrap from 23 to 00 and advance the date and the weekday; the weekday wraps from 6 to 0.
- R7: A date wraps to 01 after the last day of its month (30 or 31, or for February 28, or 29 when the year is divisible by 4) and advances the month. December wraps to January and advances the year.
- R8: The year is four BCD digits with full carry; 3999 wraps to 0000.
- R9: Bit 0 of a control read is 1 while running during the `GUARD_CYCLES` cycles up to and including each update edge and during the `GUARD_CYCLES` cycles from each update or stop release; otherwise it is 0. It is always 0 while stopped unless a rounding command is pending.
- R10: Writing 1 to control bit 0 rounds on the next edge: seconds become 00, and if they were 30 or more the minute advances with full carry. This works whether stopped or running. The bit reads 0 from the second edge after the write.
- R11: Address 1 bit 3 (oscillator-stop flag) and address 14 bits 3:2 (test/temperature flags) are plain storage bits. They are written and read back with their nibbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also sets the second period |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Nibble address for read and write |
| wr_en | input | 1 | Write strobe for `wr_data` at `addr` |
| wr_data | input | 4 | Write data |
| rd_data | output | 4 | Registered read data of the previous cycle's address |

## Verification
The bench targets the following corners:
- The 23:59:59 rollover into the next day.
- Month ends for 30- and 31-day months, February in leap and common years, and year 2100, which counts as leap under the divisible-by-4 rule.
- The 3999 year wrap.

A design with a wrong month table or leap test would land on the wrong date. One with a broken carry would leave a tens digit at 6 or skip the year.

The busy bit is checked on every cycle across two second periods. An off-by-one in the window or in the phase of the prescaler shows up as a mismatch at an edge of the window.

Rounding is tried at 45 and at 29 seconds. A core that carried on the wrong threshold, or never cleared the command, would miss the new year or leave the bit set. Writes while another bank is selected must leave the time untouched.

// File: rtl/rtc_core_pkg.sv
package rtc_core_pkg;
  localparam int NREG = 15;

  localparam logic [3:0] IX_S1    = 4'd0;
  localparam logic [3:0] IX_S10   = 4'd1;
  localparam logic [3:0] IX_M1    = 4'd2;
  localparam logic [3:0] IX_M10   = 4'd3;
  localparam logic [3:0] IX_H1    = 4'd4;
  localparam logic [3:0] IX_H10   = 4'd5;
  localparam logic [3:0] IX_DOW   = 4'd6;
  localparam logic [3:0] IX_D1    = 4'd7;
  localparam logic [3:0] IX_D10   = 4'd8;
  localparam logic [3:0] IX_MO1   = 4'd9;
  localparam logic [3:0] IX_MO10  = 4'd10;
  localparam logic [3:0] IX_Y1    = 4'd11;
  localparam logic [3:0] IX_Y10   = 4'd12;
  localparam logic [3:0] IX_Y100  = 4'd13;
  localparam logic [3:0] IX_Y1000 = 4'd14;
  localparam logic [3:0] IX_CTRL  = 4'd15;

  typedef logic [NREG-1:0][3:0] tfile_t;

  // Bits of each time nibble that carry digit weight
  function automatic logic [3:0] fld_mask(logic [3:0] ix);
    case (ix)
      IX_S10, IX_M10, IX_DOW: fld_mask = 4'b0111;
      IX_H10, IX_D10, IX_Y1000: fld_mask = 4'b0011;
      IX_MO10: fld_mask = 4'b0001;
      IX_CTRL: fld_mask = 4'b0000;
      default: fld_mask = 4'b1111;
    endcase
  endfunction

  // Two-digit year divisible by four (100 is a multiple of 4)
  function automatic logic is_leap(logic [3:0] y10, logic [3:0] y1);
    if (y10[0]) is_leap = (y1 == 4'd2) || (y1 == 4'd6);
    else        is_leap = (y1 == 4'd0) || (y1 == 4'd4) || (y1 == 4'd8);
  endfunction

  // Last date of a month, BCD {tens, units}
  function automatic logic [7:0] month_len(logic [3:0] mo10, logic [3:0] mo1, logic leap);
    if (mo10[0]) month_len = (mo1 == 4'd1) ? 8'h30 : 8'h31;
    else if (mo1 == 4'd2) month_len = leap ? 8'h29 : 8'h28;
    else if (mo1 == 4'd4 || mo1 == 4'd6 || mo1 == 4'd9) month_len = 8'h30;
    else month_len = 8'h31;
  endfunction

  // {carry, next digit}
  function automatic logic [4:0] dig_inc(logic [3:0] d, logic [3:0] last);
    dig_inc = (d == last) ? 5'b1_0000 : {1'b0, d + 4'd1};
  endfunction
endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
  parameter int SEC_CYCLES   = 32768,
  parameter int GUARD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic tick,
  output logic busy
);
  localparam int CW = (SEC_CYCLES > 2) ? $clog2(SEC_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SEC_CYCLES - 1);
  localparam logic [CW-1:0] GLO  = CW'(GUARD_CYCLES);
  localparam logic [CW-1:0] GHI  = CW'(SEC_CYCLES - GUARD_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || hold) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = !hold && (cnt == LAST);
  assign busy = !hold && ((cnt < GLO) || (cnt >= GHI));
endmodule

// File: rtl/rtc_advance.sv
module rtc_advance
  import rtc_core_pkg::*;
(
  input  tfile_t cur,
  input  logic   step_sec,
  input  logic   round_adj,
  output tfile_t nxt
);
  always_comb begin
    logic [4:0] r;
    logic c_min, c_hr, c_day, c_mon, c_yr;
    nxt = cur;
    r = '0;
    c_min = 1'b0; c_hr = 1'b0; c_day = 1'b0; c_mon = 1'b0; c_yr = 1'b0;

    if (round_adj) begin
      nxt[IX_S1]  = 4'd0;
      nxt[IX_S10] = 4'd0;
      c_min = (cur[IX_S10] >= 4'd3);
    end else if (step_sec) begin
      r = dig_inc(cur[IX_S1], 4'd9);
      nxt[IX_S1] = r[3:0];
      if (r[4]) begin
        r = dig_inc(cur[IX_S10], 4'd5);
        nxt[IX_S10] = r[3:0];
        c_min = r[4];
      end
    end

    if (c_min) begin
      r = dig_inc(cur[IX_M1], 4'd9);
      nxt[IX_M1] = r[3:0];
      if (r[4]) begin
        r = dig_inc(cur[IX_M10], 4'd5);
        nxt[IX_M10] = r[3:0];
        c_hr = r[4];
      end
    end

    if (c_hr) begin
      if (cur[IX_H10] == 4'd2 && cur[IX_H1] == 4'd3) begin
        nxt[IX_H10] = 4'd0;
        nxt[IX_H1]  = 4'd0;
        c_day = 1'b1;
      end else begin
        r = dig_inc(cur[IX_H1], 4'd9);
        nxt[IX_H1] = r[3:0];
        if (r[4]) nxt[IX_H10] = cur[IX_H10] + 4'd1;
      end
    end

    if (c_day) begin
      nxt[IX_DOW] = (cur[IX_DOW] == 4'd6) ? 4'd0 : cur[IX_DOW] + 4'd1;
      if ({cur[IX_D10], cur[IX_D1]} ==
          month_len(cur[IX_MO10], cur[IX_MO1], is_leap(cur[IX_Y10], cur[IX_Y1]))) begin
        nxt[IX_D10] = 4'd0;
        nxt[IX_D1]  = 4'd1;
        c_mon = 1'b1;
      end else begin
        r = dig_inc(cur[IX_D1], 4'd9);
        nxt[IX_D1] = r[3:0];
        if (r[4]) nxt[IX_D10] = cur[IX_D10] + 4'd1;
      end
    end

    if (c_mon) begin
      if (cur[IX_MO10] == 4'd1 && cur[IX_MO1] == 4'd2) begin
        nxt[IX_MO10] = 4'd0;
        nxt[IX_MO1]  = 4'd1;
        c_yr = 1'b1;
      end else if (cur[IX_MO1] == 4'd9) begin
        nxt[IX_MO10] = 4'd1;
        nxt[IX_MO1]  = 4'd0;
      end else begin
        nxt[IX_MO1] = cur[IX_MO1] + 4'd1;
      end
    end

    if (c_yr) begin
      r = dig_inc(cur[IX_Y1], 4'd9);
      nxt[IX_Y1] = r[3:0];
      if (r[4]) begin
        r = dig_inc(cur[IX_Y10], 4'd9);
        nxt[IX_Y10] = r[3:0];
        if (r[4]) begin
          r = dig_inc(cur[IX_Y100], 4'd9);
          nxt[IX_Y100] = r[3:0];
          if (r[4]) begin
            r = dig_inc(cur[IX_Y1000], 4'd3);
            nxt[IX_Y1000] = r[3:0];
          end
        end
      end
    end
  end
endmodule

// File: rtl/rtc_nibble_core.sv
module rtc_nibble_core
  import rtc_core_pkg::*;
#(
  parameter int SEC_CYCLES   = 32768,
  parameter int GUARD_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] addr,
  input  logic       wr_en,
  input  logic [3:0] wr_data,
  output logic [3:0] rd_data
);
  tfile_t     tf, tf_adv;
  logic       fos;
  logic [1:0] tt;
  logic [1:0] bank;
  logic       stop, adj_pend;
  logic       tick, busy;
  logic       wr_time, wr_ctrl;
  logic [3:0] rd_next;

  rtc_prescale #(.SEC_CYCLES(SEC_CYCLES), .GUARD_CYCLES(GUARD_CYCLES)) u_pre (
    .clk(clk), .rst(rst), .hold(stop), .tick(tick), .busy(busy)
  );

  rtc_advance u_adv (
    .cur(tf), .step_sec(tick), .round_adj(adj_pend), .nxt(tf_adv)
  );

  assign wr_ctrl = wr_en && (addr == IX_CTRL);
  assign wr_time = wr_en && (addr != IX_CTRL) && (bank == 2'b00);

  always_comb begin
    rd_next = 4'h0;
    if (addr == IX_CTRL) begin
      rd_next = {bank, stop, busy | adj_pend};
    end else if (bank == 2'b00) begin
      rd_next = tf[addr];
      if (addr == IX_S10)   rd_next[3]   = fos;
      if (addr == IX_Y1000) rd_next[3:2] = tt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tf          <= '0;
      tf[IX_D1]   <= 4'd1;
      tf[IX_MO1]  <= 4'd1;
      fos         <= 1'b1;
      tt          <= 2'b00;
      bank        <= 2'b00;
      stop        <= 1'b0;
      adj_pend    <= 1'b0;
      rd_data     <= 4'h0;
    end else begin
      // A write wins over an update for its own nibble only
      for (int i = 0; i < NREG; i++) begin
        if (wr_time && addr == 4'(i)) tf[i] <= wr_data & fld_mask(4'(i));
        else                          tf[i] <= tf_adv[i];
      end
      if (wr_time && addr == IX_S10)   fos <= wr_data[3];
      if (wr_time && addr == IX_Y1000) tt  <= wr_data[3:2];
      if (wr_ctrl) {bank, stop} <= wr_data[3:1];
      adj_pend <= wr_ctrl && wr_data[0];
      rd_data  <= rd_next;
    end
  end
endmodule

// File: rtl/rtc_nibble_core_chk.sv
module rtc_nibble_core_chk
  import rtc_core_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       stop,
  input logic       adj_pend,
  input logic       tick,
  input logic       busy,
  input logic       wr_en,
  input logic [3:0] addr,
  input logic [1:0] bank,
  input tfile_t     tf,
  input logic [3:0] rd_data
);
  assert_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    (stop && !adj_pend && !wr_en) |=> $stable(tf));

  assert_update_in_window_R9: assert property (@(posedge clk) disable iff (rst)
    tick |-> busy);

  assert_stopped_idle_R9: assert property (@(posedge clk) disable iff (rst)
    stop |-> !busy);

  assert_round_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (adj_pend && !wr_en) |=> !adj_pend);

  assert_round_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (adj_pend && !wr_en) |=> (tf[IX_S1] == 4'd0 && tf[IX_S10] == 4'd0));

  assert_other_bank_blank_R3: assert property (@(posedge clk) disable iff (rst)
    (bank != 2'b00 && addr != IX_CTRL) |=> (rd_data == 4'h0));
endmodule

bind rtc_nibble_core rtc_nibble_core_chk u_chk (
  .clk(clk), .rst(rst), .stop(stop), .adj_pend(adj_pend), .tick(tick),
  .busy(busy), .wr_en(wr_en), .addr(addr), .bank(bank), .tf(tf), .rd_data(rd_data)
);

// File: tb/test_rtc_nibble_core.sv
module test_rtc_nibble_core;
  localparam int SEC = 64;
  localparam int GRD = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] addr = 4'h0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_data = 4'h0;
  logic [3:0] rd_data;

  int n_tests = 0;
  int n_fail  = 0;

  // model state
  int ms, mmi, mh, mdw, md, mmo, my;
  logic exp_fos;

  always #4 clk = ~clk;

  rtc_nibble_core #(.SEC_CYCLES(SEC), .GUARD_CYCLES(GRD)) i_rtc_nibble_core (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  function automatic int dim(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [3:0] exp_nib(int ix);
    case (ix)
      0: return 4'(ms % 10);
      1: return {exp_fos, 3'(ms / 10)};
      2: return 4'(mmi % 10);
      3: return 4'(mmi / 10);
      4: return 4'(mh % 10);
      5: return 4'(mh / 10);
      6: return 4'(mdw);
      7: return 4'(md % 10);
      8: return 4'(md / 10);
      9: return 4'(mmo % 10);
      10: return 4'(mmo / 10);
      11: return 4'(my % 10);
      12: return 4'((my / 10) % 10);
      13: return 4'((my / 100) % 10);
      default: return 4'(my / 1000);
    endcase
  endfunction

  task automatic inc_minute();
    mmi++;
    if (mmi == 60) begin
      mmi = 0; mh++;
      if (mh == 24) begin
        mh = 0; mdw = (mdw + 1) % 7; md++;
        if (md > dim(mmo, my)) begin
          md = 1; mmo++;
          if (mmo == 13) begin mmo = 1; my = (my + 1) % 4000; end
        end
      end
    end
  endtask

  task automatic model_step();
    ms++;
    if (ms == 60) begin ms = 0; inc_minute(); end
  endtask

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [3:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [3:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic check_time(string tag);
    logic [3:0] v;
    for (int ix = 0; ix < 15; ix++) begin
      rd(4'(ix), v);
      check(tag, v, exp_nib(ix));
    end
  endtask

  task automatic set_time(int s, int mi, int h, int dw, int d, int mo, int y);
    wr(4'hF, 4'b0010);
    ms = s; mmi = mi; mh = h; mdw = dw; md = d; mmo = mo; my = y; exp_fos = 1'b0;
    for (int ix = 0; ix < 15; ix++) wr(4'(ix), exp_nib(ix));
  endtask

  // release, let n updates happen, stop again
  task automatic run_secs(int n);
    wr(4'hF, 4'b0000);
    repeat (n * SEC + 4) @(negedge clk);
    wr(4'hF, 4'b0010);
    for (int k = 0; k < n; k++) model_step();
  endtask

  initial begin
    #(8 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] v;
    void'($urandom(32'd7301));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R2 reset state
    ms = 0; mmi = 0; mh = 0; mdw = 0; md = 1; mmo = 1; my = 0; exp_fos = 1'b1;
    check_time("R2");
    rd(4'hF, v);
    check("R2", {v[3:1], 1'b0}, 4'h0);

    // R4 first update lands SEC edges after stop release
    set_time(7, 0, 0, 0, 1, 1, 2000);
    wr(4'hF, 4'b0000);
    addr = 4'h0;
    repeat (SEC - 1) @(negedge clk);
    check("R4 before update", rd_data, 4'd7);
    @(negedge clk);
    check("R4 before update", rd_data, 4'd7);
    @(negedge clk);
    check("R4 after update", rd_data, 4'd8);
    wr(4'hF, 4'b0010);
    model_step();
    check_time("R4");

    // R9 busy window sampled on every cycle over two periods
    wr(4'hF, 4'b0000);
    for (int k = 1; k <= 2 * SEC + 8; k++) begin
      @(negedge clk);
      check("R9", rd_data,
            {3'b000, (((k - 1) % SEC) < GRD) || (((k - 1) % SEC) >= SEC - GRD)});
    end
    wr(4'hF, 4'b0010);
    model_step(); model_step();
    check_time("R9 time after busy run");
    rd(4'hF, v);
    check("R9 stopped", v, 4'b0010);

    // R5 frozen while stopped
    repeat (3 * SEC) @(negedge clk);
    check_time("R5");

    // R6 day rollover with weekday wrap
    set_time(59, 59, 23, 6, 14, 6, 2010);
    run_secs(1);
    check_time("R6");
    set_time(58, 9, 19, 2, 9, 3, 1234);
    run_secs(2);
    check_time("R6");

    // R7 month lengths and leap years
    set_time(59, 59, 23, 3, 28, 2, 2024); run_secs(1); check_time("R7 leap feb28");
    set_time(59, 59, 23, 4, 29, 2, 2024); run_secs(1); check_time("R7 leap feb29");
    set_time(59, 59, 23, 1, 28, 2, 2023); run_secs(1); check_time("R7 common feb");
    set_time(59, 59, 23, 0, 28, 2, 2100); run_secs(1); check_time("R7 year 2100");
    set_time(59, 59, 23, 5, 30, 4, 1987); run_secs(1); check_time("R7 april");
    set_time(59, 59, 23, 5, 30, 9, 1987); run_secs(1); check_time("R7 september");
    set_time(59, 59, 23, 5, 30, 1, 1987); run_secs(1); check_time("R7 jan30");

    // R8 year carries and wrap
    set_time(59, 59, 23, 2, 31, 12, 1999); run_secs(1); check_time("R8 1999");
    set_time(59, 59, 23, 2, 31, 12, 3999); run_secs(1); check_time("R8 3999");

    // R10 rounding up with full carry, while stopped
    set_time(45, 59, 23, 6, 31, 12, 1999);
    wr(4'hF, 4'b0011);
    rd(4'hF, v);
    check("R10 self clear", v, 4'b0010);
    ms = 0; inc_minute();
    check_time("R10 round up");
    // R10 rounding down
    set_time(29, 10, 8, 1, 5, 5, 2005);
    wr(4'hF, 4'b0011);
    ms = 0;
    check_time("R10 round down");

    // R3 other bank: blank reads, writes ignored
    wr(4'hF, 4'b0110);
    wr(4'h0, 4'h7);
    rd(4'h0, v); check("R3 blank", v, 4'h0);
    rd(4'h9, v); check("R3 blank", v, 4'h0);
    rd(4'hF, v); check("R3 ctrl", v, 4'b0110);
    wr(4'hF, 4'b1110);
    rd(4'hF, v); check("R3 ctrl", v, 4'b1110);
    wr(4'hF, 4'b0010);
    check_time("R3 untouched");

    // R11 flag bits as storage
    wr(4'h1, {1'b1, 3'(ms / 10)});
    exp_fos = 1'b1;
    rd(4'h1, v); check("R11 fos", v, exp_nib(1));
    wr(4'hE, {2'b11, 2'(my / 1000)});
    rd(4'hE, v); check("R11 test/temp", v, {2'b11, 2'(my / 1000)});
    wr(4'hE, {2'b00, 2'(my / 1000)});
    rd(4'hE, v); check("R11 test/temp", v, exp_nib(14));
    // R1 unused bits stay zero through a masked write
    wr(4'hA, 4'b1110 | 4'(mmo / 10));
    rd(4'hA, v); check("R1 mask", v, 4'(mmo / 10));

    // random trials biased toward rollovers
    for (int t = 0; t < 14; t++) begin
      int s, mi, h, dw, mo, y, d, n;
      s  = 55 + int'($urandom % 5);
      mi = ($urandom % 2) ? 59 : int'($urandom % 60);
      h  = ($urandom % 2) ? 23 : int'($urandom % 24);
      dw = int'($urandom % 7);
      mo = 1 + int'($urandom % 12);
      y  = int'($urandom % 4000);
      d  = ($urandom % 2) ? dim(mo, y) : 1 + int'($urandom % dim(mo, y));
      n  = 1 + int'($urandom % 6);
      set_time(s, mi, h, dw, d, mo, y);
      run_secs(n);
      check_time("R6 R7 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule